// File: doc/BRIEF.md
# Oscillator Loss Watchdog with Limp Clock Failover

This block supervises an external reference oscillator and keeps the core clocked if that oscillator dies. It works entirely in one fast sampling clock domain. Each clock source is presented as a one-cycle enable strobe: the oscillator, the PLL output and a free-running limp oscillator. The block emits a core-clock enable strobe that the rest of the chip qualifies its registers with. In normal operation that strobe is derived from the oscillator when the PLL multiplier is zero (bypass), or from the PLL output when the multiplier is nonzero. It is then divided by 4, 2 or 1 as chosen by a 2-bit divide field.

A watchdog counts limp strobes and is cleared by every reference strobe. If a fixed number of limp strobes pass without a reference strobe, the oscillator is declared lost. The core source then moves to the limp strobe, a sticky loss flag is set, and a reset request of fixed length is issued once. The divide ratio applied to the limp source depends on the situation when the loss was detected: whether the PLL was in use, and whether the core was running or in a low-power mode.

In standby the core enable is suppressed, but supervision continues. In halt the core enable is also suppressed. The watchdog is then referenced to the PLL-output strobe, and it is held cleared until the power-up-complete input is asserted.

Top module: `mcd_limp_switch`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs (`core_en`, `miss_flag`, `rst_req`, `on_limp`) are 0 after that edge.
- R2: With `pll_mult` = 0 and no loss, `core_en` pulses once per 4, 2 or 1 `osc_tick` strobes for `div_sel` = 00, 01 or 1x. The pulse appears in the cycle after the strobe that completes the count, and only while `mode` = 00 (run).
- R3: With `pll_mult` nonzero and no loss, the same division as R2 is applied to `vco_tick` instead of `osc_tick`.
- R4: Outside halt, every `osc_tick` clears the watchdog. When the 64th consecutive `limp_tick` arrives with no clearing strobe (`TIMEOUT` = 64), a loss is detected. In the cycle after that strobe, `miss_flag` and `on_limp` are both 1.
- R5: After a loss, `core_en` is derived from `limp_tick`. The divide is /2 if the PLL was enabled at detection. In bypass it is /1 when `div_sel[1]` = 1 and /2 otherwise if detection happened in run. In bypass it follows the R2 mapping of `div_sel` if detection happened in standby or halt.
- R6: `mode` encodes 00 = run, 01 = standby, 1x = halt. Before a loss, `core_en` stays 0 in standby and halt, while detection remains active in standby.
- R7: In halt, `vco_tick` (not `osc_tick`) clears the watchdog. The watchdog is held cleared while `pwr_ready` = 0, so no loss is detected then.
- R8: `miss_flag` is cleared only by reset or by `stat_clr` = 1. A detection in the same cycle as `stat_clr` leaves it set.
- R9: `rst_req` rises in the same cycle as `on_limp`. It stays high for exactly 16 further `limp_tick` strobes (`RST_TICKS` = 16) and falls in the cycle after the 16th. It is issued once per detection.
- R10: Once set, `on_limp` stays 1 until reset, and no further detection occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per reference oscillator period |
| vco_tick | input | 1 | One-cycle strobe per PLL output period |
| limp_tick | input | 1 | One-cycle strobe per limp oscillator period |
| pll_mult | input | MULT_W | PLL multiplier; 0 selects bypass |
| div_sel | input | 2 | Core divide select: 00 /4, 01 /2, 1x /1 |
| mode | input | 2 | 00 run, 01 standby, 1x halt |
| pwr_ready | input | 1 | Oscillator and PLL power-up complete (used in halt) |
| stat_clr | input | 1 | Clears the sticky loss flag |
| core_en | output | 1 | Core clock enable strobe |
| miss_flag | output | 1 | Sticky oscillator-loss flag |
| rst_req | output | 1 | Reset request pulse after a loss |
| on_limp | output | 1 | Core is running from the limp source |

## Verification
Two events can land in one cycle: a loss detection and a software clear of the loss flag. The bench holds `stat_clr` high continuously while the oscillator is stopped in standby. The detecting limp strobe therefore coincides with a clear. The flag must read 1 in the following cycle and drop only one cycle later. A second collision is a detection edge landing on a source strobe that would complete a divide count. The cycle-accurate model expects the enable to be suppressed there and the divide count to restart on the limp source. Every cycle is compared against that model.

// File: rtl/mcd_pkg.sv
// Shared types and helpers for the oscillator-loss failover block.
package mcd_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_STBY  = 2'b01,
        MODE_HALT  = 2'b10,
        MODE_HALTX = 2'b11
    } mode_e;

    localparam int RATIO_W = 3;

    // Normal divide mapping: 00 -> 4, 01 -> 2, 1x -> 1.
    function automatic logic [RATIO_W-1:0] sel_ratio(input logic [1:0] sel);
        logic [RATIO_W-1:0] r;
        case (sel)
            2'b00:   r = 3'd4;
            2'b01:   r = 3'd2;
            default: r = 3'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mcd_watchdog.sv
// Counts limp strobes since the last reference strobe and flags a trip
// when TIMEOUT of them pass unanswered.
// Assumes: trip is combinational and valid only in the cycle it is high;
// the counter is cleared whenever the enable is low.
module mcd_watchdog #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_tick,
    input  logic limp_tick,
    output logic trip
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    // Trip on the limp strobe that would reach the threshold.
    always_comb begin
        trip = enable && !ref_tick && limp_tick && (cnt_q == LAST);
    end

    // Advance on limp strobes, clear on reference strobes or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || ref_tick || trip) begin
            cnt_q <= '0;
        end else if (limp_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mcd_rst_pulse.sv
// Stretches a one-cycle trigger into a request lasting WIDTH limp strobes.
// Assumes: the trigger loads the count without consuming a limp strobe.
module mcd_rst_pulse #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic limp_tick,
    output logic req
);
    localparam int RW = $clog2(WIDTH + 1);

    logic [RW-1:0] left_q;

    // Load on trigger, count down one per limp strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= RW'(WIDTH);
        end else if (limp_tick && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Request is high while strobes remain.
    always_comb begin
        req = (left_q != '0);
    end
endmodule

// File: rtl/mcd_clk_div.sv
// Divides the selected source strobe by a ratio of 1, 2 or 4 and emits a
// registered core enable.
// Assumes: restart clears the phase and suppresses the enable in that cycle.
module mcd_clk_div
    import mcd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_tick,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               gate_ok,
    input  logic               restart,
    output logic               en
);
    logic [RATIO_W-2:0] phase_q;
    logic               en_q;
    logic               wrap;

    // The count wraps once it reaches the last phase for the current ratio.
    always_comb begin
        wrap = ({1'b0, phase_q} >= (ratio - 1'b1));
    end

    // Step the phase per source strobe and pulse the enable on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
            en_q    <= 1'b0;
        end else if (src_tick) begin
            phase_q <= wrap ? '0 : phase_q + 1'b1;
            en_q    <= wrap && gate_ok;
        end else begin
            en_q    <= 1'b0;
        end
    end

    assign en = en_q;
endmodule

// File: rtl/mcd_limp_switch.sv
// Top of the oscillator-loss failover block: picks the reference for the
// watchdog, latches the failover context, selects and divides the core
// source, and drives the sticky flag and the reset request.
// Assumes: all clocks arrive as single-cycle strobes in the clk domain.
module mcd_limp_switch
    import mcd_pkg::*;
#(
    parameter int MULT_W    = 4,
    parameter int TIMEOUT   = 64,
    parameter int RST_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              vco_tick,
    input  logic              limp_tick,
    input  logic [MULT_W-1:0] pll_mult,
    input  logic [1:0]        div_sel,
    input  logic [1:0]        mode,
    input  logic              pwr_ready,
    input  logic              stat_clr,
    output logic              core_en,
    output logic              miss_flag,
    output logic              rst_req,
    output logic              on_limp
);
    mode_e              mode_c;
    logic               in_halt;
    logic               pll_on;
    logic               wd_en;
    logic               wd_ref;
    logic               trip;
    logic               src_tick;
    logic               gate_ok;
    logic [RATIO_W-1:0] ratio;
    logic               limp_q;
    logic               miss_q;
    logic               ctx_pll_q;
    logic               ctx_run_q;

    // Decode the mode and the PLL use.
    always_comb begin
        mode_c  = mode_e'(mode);
        in_halt = (mode_c == MODE_HALT) || (mode_c == MODE_HALTX);
        pll_on  = |pll_mult;
    end

    // Watchdog reference and enable: PLL side in halt, oscillator otherwise.
    always_comb begin
        wd_ref = in_halt ? vco_tick : osc_tick;
        wd_en  = !limp_q && (!in_halt || pwr_ready);
    end

    mcd_watchdog #(.TIMEOUT(TIMEOUT)) i_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (wd_en),
        .ref_tick  (wd_ref),
        .limp_tick (limp_tick),
        .trip      (trip)
    );

    // Latch the failover state and the context seen at detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limp_q    <= 1'b0;
            ctx_pll_q <= 1'b0;
            ctx_run_q <= 1'b0;
        end else if (trip) begin
            limp_q    <= 1'b1;
            ctx_pll_q <= pll_on;
            ctx_run_q <= (mode_c == MODE_RUN);
        end
    end

    // Sticky loss flag: a detection wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= 1'b0;
        end else if (trip) begin
            miss_q <= 1'b1;
        end else if (stat_clr) begin
            miss_q <= 1'b0;
        end
    end

    // Core source strobe and divide ratio for the current context.
    always_comb begin
        if (limp_q) begin
            src_tick = limp_tick;
            if (ctx_pll_q) begin
                ratio = 3'd2;
            end else if (ctx_run_q) begin
                ratio = div_sel[1] ? 3'd1 : 3'd2;
            end else begin
                ratio = sel_ratio(div_sel);
            end
        end else begin
            src_tick = pll_on ? vco_tick : osc_tick;
            ratio    = sel_ratio(div_sel);
        end
        gate_ok = limp_q || (mode_c == MODE_RUN);
    end

    mcd_clk_div i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .ratio    (ratio),
        .gate_ok  (gate_ok),
        .restart  (trip),
        .en       (core_en)
    );

    mcd_rst_pulse #(.WIDTH(RST_TICKS)) i_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (trip),
        .limp_tick (limp_tick),
        .req       (rst_req)
    );

    assign miss_flag = miss_q;
    assign on_limp   = limp_q;
endmodule

// File: rtl/mcd_limp_switch_chk.sv
// Protocol checks on the ports of the failover block, bound to its top.
module mcd_limp_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       stat_clr,
    input logic       core_en,
    input logic       miss_flag,
    input logic       rst_req,
    input logic       on_limp
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!core_en && !miss_flag && !rst_req && !on_limp));

    // R4
    flag_with_limp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_limp) |-> miss_flag);

    // R6
    core_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> ($past(on_limp) || $past(mode) == 2'b00));

    // R8
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miss_flag) |-> $past(stat_clr));

    // R9
    req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $rose(on_limp));

    // R10
    limp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_limp |=> on_limp);
endmodule

bind mcd_limp_switch mcd_limp_switch_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .stat_clr  (stat_clr),
    .core_en   (core_en),
    .miss_flag (miss_flag),
    .rst_req   (rst_req),
    .on_limp   (on_limp)
);

// File: tb/test_mcd_limp_switch.sv
module test_mcd_limp_switch;
    localparam int MULT_W    = 4;
    localparam int TIMEOUT   = 64;
    localparam int RST_TICKS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              osc_tick = 1'b0, vco_tick = 1'b0, limp_tick = 1'b0;
    logic [MULT_W-1:0] pll_mult = '0;
    logic [1:0]        div_sel = 2'b00;
    logic [1:0]        mode = 2'b00;
    logic              pwr_ready = 1'b0;
    logic              stat_clr = 1'b0;
    logic              core_en, miss_flag, rst_req, on_limp;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int p_osc = 3, p_vco = 2, p_limp = 5;
    int c_osc = 0, c_vco = 0, c_limp = 0;

    always #10 clk = ~clk;

    mcd_limp_switch #(.MULT_W(MULT_W), .TIMEOUT(TIMEOUT), .RST_TICKS(RST_TICKS)) i_mcd_limp_switch (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .vco_tick(vco_tick),
        .limp_tick(limp_tick), .pll_mult(pll_mult), .div_sel(div_sel),
        .mode(mode), .pwr_ready(pwr_ready), .stat_clr(stat_clr),
        .core_en(core_en), .miss_flag(miss_flag), .rst_req(rst_req), .on_limp(on_limp));

    // Strobe generators for the three sources (period 0 = stopped).
    always @(negedge clk) begin
        if (p_osc == 0) osc_tick <= 1'b0;
        else begin c_osc = (c_osc + 1) % p_osc; osc_tick <= (c_osc == 0); end
        if (p_vco == 0) vco_tick <= 1'b0;
        else begin c_vco = (c_vco + 1) % p_vco; vco_tick <= (c_vco == 0); end
        if (p_limp == 0) limp_tick <= 1'b0;
        else begin c_limp = (c_limp + 1) % p_limp; limp_tick <= (c_limp == 0); end
    end

    // Behavioural reference model.
    int m_wd = 0, m_ph = 0, m_left = 0;
    bit m_en = 0, m_miss = 0, m_limp = 0, m_cpll = 0, m_crun = 0;

    function automatic int norm_div(input logic [1:0] s);
        if (s == 2'b00) return 4;
        if (s == 2'b01) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit halt, rf, wen, hit, src, gate;
        int ratio;
        if (!rst_n) begin
            m_wd = 0; m_ph = 0; m_left = 0;
            m_en = 0; m_miss = 0; m_limp = 0; m_cpll = 0; m_crun = 0;
        end else begin
            halt = mode[1];
            rf   = halt ? vco_tick : osc_tick;
            wen  = !m_limp && (!halt || pwr_ready);
            hit  = 0;
            if (!wen || rf) m_wd = 0;
            else if (limp_tick) begin
                if (m_wd == TIMEOUT - 1) begin hit = 1; m_wd = 0; end
                else m_wd = m_wd + 1;
            end
            if (m_limp) begin
                src = limp_tick;
                if (m_cpll) ratio = 2;
                else if (m_crun) ratio = div_sel[1] ? 1 : 2;
                else ratio = norm_div(div_sel);
            end else begin
                src = (pll_mult != 0) ? vco_tick : osc_tick;
                ratio = norm_div(div_sel);
            end
            gate = m_limp || (mode == 2'b00);
            if (hit) begin m_ph = 0; m_en = 0; end
            else if (src) begin
                if (m_ph >= ratio - 1) begin m_ph = 0; m_en = gate; end
                else begin m_ph = m_ph + 1; m_en = 0; end
            end else m_en = 0;
            if (hit) m_left = RST_TICKS;
            else if (limp_tick && m_left > 0) m_left = m_left - 1;
            if (hit) m_miss = 1;
            else if (stat_clr) m_miss = 0;
            if (hit) begin
                m_limp = 1; m_cpll = (pll_mult != 0); m_crun = (mode == 2'b00);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!finished && rst_n) begin
            if (m_limp) check("R5 core_en on limp", core_en, m_en);
            else if (mode != 2'b00) check("R6 core_en gated", core_en, m_en);
            else if (pll_mult != 0) check("R3 core_en from vco", core_en, m_en);
            else check("R2 core_en from osc", core_en, m_en);
            check(stat_clr ? "R8 miss_flag clear" : "R4 miss_flag", miss_flag, m_miss);
            check("R9 rst_req", rst_req, m_left > 0);
            check("R10 on_limp", on_limp, m_limp);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cycles(3);
        check("R1 core_en reset", core_en, 1'b0);
        check("R1 miss_flag reset", miss_flag, 1'b0);
        check("R1 rst_req reset", rst_req, 1'b0);
        check("R1 on_limp reset", on_limp, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1 and R2: bypass, all three divide settings.
        do_reset();
        pll_mult = '0; mode = 2'b00;
        for (int s = 0; s < 4; s++) begin div_sel = 2'(s); cycles(60); end
        // R3: PLL enabled, vco strobe period 2.
        pll_mult = 4'd5;
        for (int s = 0; s < 4; s++) begin div_sel = 2'(s); cycles(60); end
        // R4, R5, R9, R10: bypass loss in run, then change div_sel.
        pll_mult = '0; div_sel = 2'b01;
        p_osc = 0;
        cycles(TIMEOUT * 5 + 20);
        check("R4 loss detected", on_limp, 1'b1);
        cycles(RST_TICKS * 5 + 20);
        check("R9 request ended", rst_req, 1'b0);
        div_sel = 2'b10; cycles(40);
        // R8: explicit clear, R10: limp stays with oscillator back.
        p_osc = 3; stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0; cycles(2);
        check("R8 flag cleared", miss_flag, 1'b0);
        check("R10 limp held", on_limp, 1'b1);
        cycles(400);
        // R6: PLL enabled, standby, then loss -> /2 of limp.
        do_reset();
        pll_mult = 4'd3; mode = 2'b01; div_sel = 2'b10; p_osc = 3;
        cycles(80);
        p_osc = 0; cycles(TIMEOUT * 5 + 20);
        check("R6 detect in standby", on_limp, 1'b1);
        cycles(200);
        // R8 collision: bypass standby, clear held across detection.
        do_reset();
        pll_mult = '0; mode = 2'b01; div_sel = 2'b00; p_osc = 3;
        cycles(40);
        stat_clr = 1'b1; p_osc = 0;
        cycles(TIMEOUT * 5 + 20);
        stat_clr = 1'b0;
        cycles(200);
        // R7: halt, power not ready, then ready with vco, then vco stops.
        do_reset();
        mode = 2'b10; pwr_ready = 1'b0; p_osc = 0; p_vco = 0; div_sel = 2'b01;
        cycles(TIMEOUT * 5 + 100);
        check("R7 held before power-up", on_limp, 1'b0);
        pwr_ready = 1'b1; p_vco = 3;
        cycles(TIMEOUT * 5 + 100);
        check("R7 vco clears in halt", on_limp, 1'b0);
        p_osc = 2; p_vco = 0;
        cycles(TIMEOUT * 5 + 20);
        check("R7 loss in halt", on_limp, 1'b1);
        cycles(200);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule